// File: doc/BRIEF.md
# Embedded-Clock 10-Bit Serializer

This block converts a 10-bit parallel word into a 12-bit serial frame. Each frame wraps the data between a high start bit and a low stop bit, so the line has at least one transition per word and a receiver can recover the word clock from it. The block runs on a bit clock twelve times faster than the word clock. A one-cycle `frame_tick` strobe marks every word boundary. The parallel word is captured on the rising or falling edge of the word clock, as software or pin strapping selects.

Two request inputs, ORed together, replace data frames with synchronization symbols: six ones followed by six zeros. Once a request has been seen, a minimum number of symbols is always sent. The serial output carries a separate drive-enable flag. The flag is low when the output enable is low, when the block is powered down, and until a lock timer has counted a fixed number of word periods after power-up. That timer stands in for the PLL lock time of an analog implementation.

Top module: `embclk_serializer`

## Requirements
- R1: The frame loaded by a `frame_tick` is shifted out one bit per clock, starting in the cycle after the tick. Bit 0 is the start bit (1), bits 1 to 10 are the data word least significant bit first, and bit 11 is the stop bit (0).
- R2: With `edge_sel` = 1 the data word is captured on a rising edge of `word_clk`; with `edge_sel` = 0 on a falling edge. The last captured word is what the next `frame_tick` loads.
- R3: A sync frame is 12'h03F in transmit order (bits 0 to 5 are 1, bits 6 to 11 are 0), whatever `data_in` holds.
- R4: If `sync_a` or `sync_b` is high at a `frame_tick`, that tick loads a sync frame.
- R5: After the last tick at which a request was high, `MIN_SYNC`-1 further ticks also load sync frames, so one request gives at least `MIN_SYNC` symbols. Data frames follow after that.
- R6: While `out_en` is low, `drive_en` is 0 and `ser_out` is 0. Framing, sync counting and locking carry on, so the stream resumes in sequence when `out_en` returns high.
- R7: While `pwr_on` is low, `drive_en` is 0, the lock state is cleared and any pending sync symbols are cancelled.
- R8: `drive_en` goes high only from the frame loaded by the `LOCK_WORDS`-th `frame_tick` with `pwr_on` high since reset or since the last power-down.
- R9: In reset and right after it, `drive_en` and `ser_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe at each word boundary |
| word_clk | input | 1 | Word clock level, sampled on `clk` |
| edge_sel | input | 1 | 1: capture on rising edge of `word_clk`, 0: on falling edge |
| data_in | input | 10 | Parallel data word |
| sync_a | input | 1 | Sync request, ORed with `sync_b` |
| sync_b | input | 1 | Sync request, ORed with `sync_a` |
| out_en | input | 1 | Output enable; low puts the output in high impedance |
| pwr_on | input | 1 | Low selects power-down |
| ser_out | output | 1 | Serial bit stream, 0 while not driven |
| drive_en | output | 1 | High when the serial output is driven |

## Verification
The assertions check on every cycle that the output is quiet while the enable is low, and that the start bit follows each tick and the stop bit precedes it while driving. They also check that a request at a tick loads exactly the sync pattern, that lock is dropped after power-down, and that lock rises only on the `LOCK_WORDS`-th powered tick. Only the bench scenarios can show the rest. These are the selected capture edge and its one-frame lag, the full count of trailing sync symbols after a request ends, and the return to data afterwards. The same holds for cancelling pending symbols across a power-down, and for the stream resuming in sequence after the enable is low for a while.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int WORD_W  = 10;
    localparam int FRAME_W = WORD_W + 2;
    localparam int HALF_W  = FRAME_W / 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_SYNC = 1'b1
    } frame_kind_e;

    // Transmit order is bit 0 first: start (1), data LSB first, stop (0).
    function automatic frame_t make_data_frame(word_t w);
        return {1'b0, w, 1'b1};
    endfunction

    // First half ones, second half zeros.
    function automatic frame_t make_sync_frame();
        frame_t f;
        for (int i = 0; i < FRAME_W; i++) begin
            f[i] = (i < HALF_W);
        end
        return f;
    endfunction

endpackage

// File: rtl/ser_capture.sv
module ser_capture
    import ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  word_clk,
    input  logic  edge_sel,
    input  word_t data_in,
    output word_t word_q
);
    logic wclk_q;
    logic hit;

    always_comb begin
        if (edge_sel) hit = word_clk & ~wclk_q;
        else          hit = ~word_clk & wclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_q <= 1'b0;
            word_q <= '0;
        end else begin
            wclk_q <= word_clk;
            if (hit) word_q <= data_in;
        end
    end
endmodule

// File: rtl/ser_lock_timer.sv
module ser_lock_timer #(
    parameter int LOCK_WORDS = 510
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_on,
    input  logic frame_tick,
    output logic locked
);
    localparam int CW = $clog2(LOCK_WORDS + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_WORDS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (frame_tick && !locked) begin
            if (cnt == LAST) locked <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ser_sync_ctrl.sv
module ser_sync_ctrl
    import ser_pkg::*;
#(
    parameter int MIN_SYNC = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_on,
    input  logic        frame_tick,
    input  logic        sync_req,
    output frame_kind_e next_kind
);
    localparam int SW = $clog2(MIN_SYNC + 1);
    localparam logic [SW-1:0] RELOAD = SW'(MIN_SYNC - 1);

    logic [SW-1:0] remain;

    assign next_kind = (sync_req || remain != '0) ? KIND_SYNC : KIND_DATA;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            remain <= '0;
        end else if (frame_tick) begin
            if (sync_req)            remain <= RELOAD;
            else if (remain != '0)   remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
    import ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_tick,
    input  frame_kind_e kind,
    input  word_t       word,
    output frame_t      frame_bits
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_bits <= '0;
        end else if (frame_tick) begin
            frame_bits <= (kind == KIND_SYNC) ? make_sync_frame()
                                              : make_data_frame(word);
        end else begin
            frame_bits <= frame_bits >> 1;
        end
    end
endmodule

// File: rtl/embclk_serializer.sv
module embclk_serializer
    import ser_pkg::*;
#(
    parameter int LOCK_WORDS = 510,
    parameter int MIN_SYNC   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic              word_clk,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] data_in,
    input  logic              sync_a,
    input  logic              sync_b,
    input  logic              out_en,
    input  logic              pwr_on,
    output logic              ser_out,
    output logic              drive_en
);
    word_t       word_q;
    frame_kind_e kind;
    frame_t      frame_bits;
    logic        locked;

    ser_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .word_clk (word_clk),
        .edge_sel (edge_sel),
        .data_in  (data_in),
        .word_q   (word_q)
    );

    ser_sync_ctrl #(.MIN_SYNC(MIN_SYNC)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .frame_tick (frame_tick),
        .sync_req   (sync_a | sync_b),
        .next_kind  (kind)
    );

    ser_lock_timer #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .frame_tick (frame_tick),
        .locked     (locked)
    );

    ser_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .kind       (kind),
        .word       (word_q),
        .frame_bits (frame_bits)
    );

    assign drive_en = locked & pwr_on & out_en;
    assign ser_out  = drive_en & frame_bits[0];
endmodule

// File: rtl/embclk_serializer_chk.sv
module embclk_serializer_chk
    import ser_pkg::*;
#(
    parameter int LOCK_WORDS = 510
) (
    input logic   clk,
    input logic   rst,
    input logic   frame_tick,
    input logic   sync_a,
    input logic   sync_b,
    input logic   out_en,
    input logic   pwr_on,
    input logic   ser_out,
    input logic   drive_en,
    input logic   locked,
    input frame_t frame_bits
);
    localparam int CW = $clog2(LOCK_WORDS + 1);
    localparam logic [CW-1:0] FULL = CW'(LOCK_WORDS);

    logic [CW-1:0] powered_ticks;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on)                        powered_ticks <= '0;
        else if (frame_tick && powered_ticks != FULL) powered_ticks <= powered_ticks + 1'b1;
    end

    assert_hiz_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!drive_en && !ser_out));

    assert_lock_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> !locked);

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> (ser_out || !drive_en));

    assert_stop_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && drive_en) |-> !ser_out);

    assert_sync_loaded_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && (sync_a || sync_b)) |=> (frame_bits == make_sync_frame()));

    assert_lock_length_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (powered_ticks == FULL));
endmodule

bind embclk_serializer embclk_serializer_chk #(.LOCK_WORDS(LOCK_WORDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .sync_a     (sync_a),
    .sync_b     (sync_b),
    .out_en     (out_en),
    .pwr_on     (pwr_on),
    .ser_out    (ser_out),
    .drive_en   (drive_en),
    .locked     (locked),
    .frame_bits (frame_bits)
);

// File: tb/test_embclk_serializer.sv
module test_embclk_serializer;
    localparam int LOCK_WORDS = 510;
    localparam int MIN_SYNC   = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic       word_clk = 1'b1;
    logic       edge_sel = 1'b1;
    logic [9:0] data_in = '0;
    logic       sync_a = 1'b0, sync_b = 1'b0;
    logic       out_en = 1'b1, pwr_on = 1'b1;
    logic       ser_out, drive_en;

    always #4 clk = ~clk;

    embclk_serializer #(.LOCK_WORDS(LOCK_WORDS), .MIN_SYNC(MIN_SYNC)) i_embclk_serializer (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .word_clk(word_clk),
        .edge_sel(edge_sel), .data_in(data_in), .sync_a(sync_a), .sync_b(sync_b),
        .out_en(out_en), .pwr_on(pwr_on), .ser_out(ser_out), .drive_en(drive_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Scoreboard queues: one entry per frame loaded at a tick.
    logic [11:0] exp_bits_q[$];
    logic [11:0] exp_drv_q[$];
    string       exp_tag_q[$];

    // Scenario controls, applied at the tick that ends each word period.
    logic ctl_sa = 1'b0, ctl_sb = 1'b0, ctl_en = 1'b1, ctl_pwr = 1'b1, ctl_edge = 1'b1;

    // Requirement-level model state.
    logic       edge_prev = 1'b1;
    logic [9:0] b_prev = '0;
    int         lock_ticks = 0;
    int         sync_rem = 0;
    int         k = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog: cycles=%0d expected fewer than 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check_val(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic one_period(input string tag);
        logic [11:0] got_bits;
        logic [11:0] got_drv;
        logic [9:0]  a_val;
        logic [9:0]  b_val;
        logic        req;
        logic        is_sync;
        logic        drv;
        logic [9:0]  word;
        logic [11:0] frame;
        a_val = 10'(k * 181 + 7);
        b_val = 10'(~(k * 53 + 3));
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            got_bits[p] = ser_out;
            got_drv[p]  = drive_en;
            frame_tick = (p == 11);
            word_clk   = (p >= 6);
            if (p == 4)  data_in = a_val;
            if (p == 10) data_in = b_val;
            if (p == 11) begin
                sync_a   = ctl_sa;
                sync_b   = ctl_sb;
                out_en   = ctl_en;
                pwr_on   = ctl_pwr;
                edge_sel = ctl_edge;
            end
        end
        // Monitor: compare the frame seen in this period.
        if (exp_bits_q.size() > 0) begin
            logic [11:0] eb;
            logic [11:0] ed;
            string       et;
            eb = exp_bits_q.pop_front();
            ed = exp_drv_q.pop_front();
            et = exp_tag_q.pop_front();
            check_val(et, $sformatf("frame %0d bits/drive", k - 1),
                      {8'h0, got_drv, got_bits}, {8'h0, ed, eb});
        end
        // Driver side: expected content of the frame loaded at this tick.
        req = ctl_sa | ctl_sb;
        if (!ctl_pwr) begin
            lock_ticks = 0;
            sync_rem   = 0;
            is_sync    = req;
        end else begin
            if (lock_ticks < LOCK_WORDS) lock_ticks++;
            is_sync = req || (sync_rem > 0);
            if (req)               sync_rem = MIN_SYNC - 1;
            else if (sync_rem > 0) sync_rem--;
        end
        drv   = ctl_pwr && ctl_en && (lock_ticks >= LOCK_WORDS);
        word  = edge_prev ? a_val : b_prev;
        frame = is_sync ? 12'h03F : {1'b0, word, 1'b1};
        exp_bits_q.push_back(drv ? frame : 12'h000);
        exp_drv_q.push_back({12{drv}});
        exp_tag_q.push_back(tag);
        edge_prev = ctl_edge;
        b_prev    = b_val;
        k++;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) one_period(tag);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check_val("R9", "drive_en in reset", {31'h0, drive_en}, 32'h0);
        check_val("R9", "ser_out in reset",  {31'h0, ser_out},  32'h0);
        rst = 1'b0;
        @(negedge clk);
        check_val("R9", "drive_en after reset", {31'h0, drive_en}, 32'h0);

        // R8: lock wait after power-up, frames undriven then driven
        run(LOCK_WORDS + 3, "R8");

        // R1: data frames captured on rising edge
        run(8, "R1");

        // R2: switch to falling-edge capture and back
        ctl_edge = 1'b0;
        run(8, "R2");
        ctl_edge = 1'b1;
        run(4, "R2");

        // R3 R4: request on sync_a, then R5 trailing symbols and return to data
        ctl_sa = 1'b1;
        run(2, "R3 R4");
        ctl_sa = 1'b0;
        run(MIN_SYNC + 4, "R5");

        // R4 via sync_b, R6 enable dropped while symbols continue
        ctl_sb = 1'b1;
        run(1, "R4");
        ctl_sb = 1'b0;
        run(20, "R5");
        ctl_en = 1'b0;
        run(12, "R6");
        ctl_en = 1'b1;
        run(MIN_SYNC, "R6");

        // R7: power-down cancels pending symbols and lock, then relock
        ctl_sa = 1'b1;
        run(1, "R7");
        ctl_sa  = 1'b0;
        ctl_pwr = 1'b0;
        run(4, "R7");
        ctl_pwr = 1'b1;
        run(LOCK_WORDS + 6, "R7");
        run(1, "R7");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule